// File: doc/BRIEF.md
# Rate-Limited Phase Offset Slewer

This block holds a signed phase-offset target and walks an applied offset toward it, one fine step at a time. Software writes an 8-bit two's-complement target through a simple write strobe. The block does not jump to that value. It issues single advance or delay step requests to a downstream clock-phase shifter, and it spaces those requests so the phase never moves faster than the selected rate limit. One step is 1/128 of a 61.035 ns period, about 477 ps. Positive targets advance every generated clock and frame pulse together, and negative targets delay them, relative to the active input reference.

Pacing runs from a 1 µs timebase tick. Each rate mode has a parameter giving the minimum number of ticks between steps. With rate select at 0 the limit is 41 ns in any 1.326 ms, so the default gap is 16 ticks (at most 83 steps in any 1326 ticks). With rate select at 1 the limit is 885 ns per second, so the default gap is 540 ticks (at most about 1852 steps per second). A new write during a slew retargets at once, and the applied offset keeps moving from wherever it currently is.

Top module: `phase_slew_ctrl`

## Requirements
- R1: While reset is held and just after it is released, rdData and appliedOfs are 0x00, busy is low, and neither stepAdv nor stepDly is asserted.
- R2: A cycle with wrEn high captures wrData as the target, an 8-bit two's-complement value from -128 (0x80) to +127 (0x7F). From the next cycle on, rdData returns that value.
- R3: Each step changes appliedOfs by exactly one. If the target is greater than appliedOfs (signed), the step adds 1 and stepAdv is high. If it is smaller, the step subtracts 1 and stepDly is high. The pulse is high for one cycle, in the same cycle the new appliedOfs first appears, and stepAdv and stepDly are never high together.
- R4: After a step, no further step is issued until at least GAP usTick pulses have arrived in the cycles that follow it. GAP is FAST_GAP when rateSel is 0 and SLOW_GAP when rateSel is 1. When usTick is high on every cycle, consecutive steps are exactly GAP+1 cycles apart.
- R5: While usTick stays low and no step credit is banked, appliedOfs does not change, even if it differs from the target.
- R6: Step credit never exceeds one step. After a long idle period with ticks running, a new target produces its first step one cycle after the write. The second step then waits for GAP further ticks.
- R7: Reset empties the step credit. The first step after reset needs GAP ticks after reset.
- R8: A write during a slew retargets immediately. appliedOfs changes by at most one per cycle, continues from its current value, and finishes at the new target.
- R9: busy is high exactly while appliedOfs differs from the target. A move from +127 to -128 completes as 255 delay steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Target write strobe |
| wrData | input | 8 | Target value to write, two's complement |
| rateSel | input | 1 | Rate mode: 0 uses FAST_GAP, 1 uses SLOW_GAP |
| usTick | input | 1 | 1 µs timebase pulse |
| rdData | output | 8 | Read-back of the target |
| appliedOfs | output | 8 | Offset currently applied, two's complement |
| busy | output | 1 | High while applied offset differs from the target |
| stepAdv | output | 1 | One-cycle request for one advance step |
| stepDly | output | 1 | One-cycle request for one delay step |

## Verification
On every cycle, the assertions check that a step moves the applied offset by exactly one in the direction of its pulse, and that the offset never changes without a pulse. They also check that advance and delay never fire together, that an idle block holds its offset, that read-back follows a write, and that the pacing count holds when there is no tick. Only the bench scenarios can show the exact spacing of GAP+1 cycles in each rate mode, the one-step cap on banked credit, the empty credit after reset, and a retarget that reverses direction and still ends on the new value.

// File: rtl/phase_slew_pkg.sv
package phase_slew_pkg;
  typedef struct packed {
    logic adv;
    logic dly;
  } stepCmd_t;
endpackage

// File: rtl/phase_slew_dp.sv
module phase_slew_dp
  import phase_slew_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [OFS_W-1:0] wrData,
  input  stepCmd_t         cmd,
  output logic             wantAdv,
  output logic             wantDly,
  output logic [OFS_W-1:0] targetOfs,
  output logic [OFS_W-1:0] curOfs,
  output logic             stepAdv,
  output logic             stepDly
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetOfs <= '0;
    end else if (wrEn) begin
      targetOfs <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOfs  <= '0;
      stepAdv <= 1'b0;
      stepDly <= 1'b0;
    end else begin
      stepAdv <= cmd.adv;
      stepDly <= cmd.dly;
      if (cmd.adv) begin
        curOfs <= curOfs + ONE;
      end else if (cmd.dly) begin
        curOfs <= curOfs - ONE;
      end
    end
  end

  always_comb begin
    wantAdv = $signed(targetOfs) > $signed(curOfs);
    wantDly = $signed(targetOfs) < $signed(curOfs);
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stepAdv && stepDly));
  p_adv_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepAdv |-> curOfs == OFS_W'($past(curOfs) + ONE));
  p_dly_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepDly |-> curOfs == OFS_W'($past(curOfs) - ONE));
  p_no_jump_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curOfs != $past(curOfs)) |-> (stepAdv || stepDly));
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> targetOfs == $past(wrData));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wantAdv && !wantDly && !wrEn) |=> $stable(curOfs));
endmodule

// File: rtl/phase_slew_ctl.sv
module phase_slew_ctl
  import phase_slew_pkg::*;
#(
  parameter int FAST_GAP = 16,
  parameter int SLOW_GAP = 540
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rateSel,
  input  logic     usTick,
  input  logic     wantAdv,
  input  logic     wantDly,
  output stepCmd_t cmd
);
  localparam int MAX_GAP = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int CW = $clog2(MAX_GAP + 1);

  logic [CW-1:0] paceCnt;
  logic [CW-1:0] gapSel;
  logic          ready;
  logic          issue;

  always_comb begin
    gapSel  = rateSel ? CW'(SLOW_GAP) : CW'(FAST_GAP);
    ready   = paceCnt >= gapSel;
    issue   = ready && (wantAdv || wantDly);
    cmd.adv = issue && wantAdv;
    cmd.dly = issue && wantDly;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paceCnt <= '0;
    end else if (issue) begin
      paceCnt <= '0;
    end else if (usTick && !ready) begin
      paceCnt <= paceCnt + CW'(1);
    end
  end

  p_no_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !cmd.adv && !cmd.dly) |=> $stable(paceCnt));
  p_cmd_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.adv && cmd.dly));
endmodule

// File: rtl/phase_slew_ctrl.sv
module phase_slew_ctrl
  import phase_slew_pkg::*;
#(
  parameter int OFS_W    = 8,
  parameter int FAST_GAP = 16,
  parameter int SLOW_GAP = 540
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [OFS_W-1:0] wrData,
  input  logic             rateSel,
  input  logic             usTick,
  output logic [OFS_W-1:0] rdData,
  output logic [OFS_W-1:0] appliedOfs,
  output logic             busy,
  output logic             stepAdv,
  output logic             stepDly
);
  stepCmd_t cmd;
  logic     wantAdv;
  logic     wantDly;

  phase_slew_dp #(.OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cmd(cmd),
    .wantAdv(wantAdv), .wantDly(wantDly), .targetOfs(rdData),
    .curOfs(appliedOfs), .stepAdv(stepAdv), .stepDly(stepDly)
  );

  phase_slew_ctl #(.FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)) u_ctl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .usTick(usTick),
    .wantAdv(wantAdv), .wantDly(wantDly), .cmd(cmd)
  );

  assign busy = wantAdv || wantDly;

  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rdData != appliedOfs));
endmodule

// File: tb/phase_slew_ctrl_bench.sv
module phase_slew_ctrl_bench;
  localparam int FG = 3;
  localparam int SG = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic rateSel = 1'b0;
  logic usTick = 1'b0;
  logic [7:0] rdData, appliedOfs;
  logic busy, stepAdv, stepDly;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int jumps = 0;
  logic [7:0] prevOfs = 8'h00;

  phase_slew_ctrl #(.OFS_W(8), .FAST_GAP(FG), .SLOW_GAP(SG)) u_phase_slew_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rateSel(rateSel),
    .usTick(usTick), .rdData(rdData), .appliedOfs(appliedOfs), .busy(busy),
    .stepAdv(stepAdv), .stepDly(stepDly)
  );

  always #2 clk = ~clk;

  // {rateSel, target}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'h05}, {1'b1, 8'hFE}, {1'b0, 8'h7F},
    {1'b0, 8'h80}, {1'b1, 8'h03}, {1'b0, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeTgt(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runIdle(output int nAdv, output int nDly, output int gapBad);
    int last;
    nAdv = 0; nDly = 0; gapBad = 0; last = -1;
    for (int i = 0; i < 5000 && busy; i++) begin
      @(negedge clk);
      if (stepAdv) nAdv++;
      if (stepDly) nDly++;
      if (stepAdv || stepDly) begin
        if (last >= 0 && (i - last) != (rateSel ? SG + 1 : FG + 1)) gapBad++;
        last = i;
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN && (appliedOfs - prevOfs != 8'h00) && (appliedOfs - prevOfs != 8'h01)
        && (appliedOfs - prevOfs != 8'hFF)) jumps++;
    prevOfs = appliedOfs;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a, d, g, expA, expD;
    logic signed [8:0] prevT, newT, diff;
    logic [7:0] peak;
    repeat (4) @(negedge clk);
    check(rdData == 8'h00 && appliedOfs == 8'h00, "R1 reset values", appliedOfs, 0);
    check(!busy && !stepAdv && !stepDly, "R1 reset flags", {busy, stepAdv, stepDly}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(appliedOfs == 8'h00 && !busy, "R1 after release", appliedOfs, 0);

    // R7/R5: reset empties credit; no ticks -> no step
    writeTgt(8'h01);
    check(rdData == 8'h01, "R2 readback", rdData, 1);
    repeat (10) @(negedge clk);
    check(appliedOfs == 8'h00 && busy, "R5 no tick no step", appliedOfs, 0);
    usTick = 1'b1;
    repeat (FG - 1) @(negedge clk);
    usTick = 1'b0;
    repeat (3) @(negedge clk);
    check(appliedOfs == 8'h00, "R7 GAP-1 ticks insufficient", appliedOfs, 0);
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
    repeat (2) @(negedge clk);
    check(appliedOfs == 8'h01 && !busy, "R7 step after GAP ticks", appliedOfs, 1);

    // Vector table, ticks every cycle
    usTick = 1'b1;
    prevT = 9'sd1;
    for (int k = 0; k < 6; k++) begin
      rateSel = VEC[k][8];
      newT = {VEC[k][7], VEC[k][7:0]};
      diff = newT - prevT;
      expA = (diff > 0) ? int'(diff) : 0;
      expD = (diff < 0) ? int'(-diff) : 0;
      writeTgt(VEC[k][7:0]);
      check(rdData == VEC[k][7:0], "R2 readback vec", rdData, VEC[k][7:0]);
      runIdle(a, d, g);
      // first step may occur in the cycle after write (banked credit), counted here
      check(appliedOfs == VEC[k][7:0] && !busy, "R9 reaches target", appliedOfs, VEC[k][7:0]);
      check(a == expA && d == expD, "R3 step count and direction", a * 1000 + d, expA * 1000 + expD);
      check(g == 0, "R4 step spacing GAP+1", g, 0);
      prevT = newT;
    end

    // R6: credit saturates at one step
    repeat (50) @(negedge clk);
    rateSel = 1'b0;
    writeTgt(8'h03);
    @(negedge clk);
    check(appliedOfs == 8'h01, "R6 immediate first step", appliedOfs, 1);
    repeat (3) @(negedge clk);
    check(appliedOfs == 8'h01, "R6 second step waits", appliedOfs, 1);
    @(negedge clk);
    check(appliedOfs == 8'h02, "R6 second step after GAP", appliedOfs, 2);
    runIdle(a, d, g);

    // R8: retarget mid-slew
    writeTgt(8'h14);
    repeat (20) @(negedge clk);
    peak = appliedOfs;
    writeTgt(8'hFD);
    runIdle(a, d, g);
    check(appliedOfs == 8'hFD && rdData == 8'hFD, "R8 retarget final", appliedOfs, 8'hFD);
    check(peak > 8'h03 && peak < 8'h14, "R8 partial before retarget", peak, 8);
    check(d == int'(peak) + 3 || d == int'(peak) + 4, "R8 continues from current", d, int'(peak) + 3);
    check(jumps == 0, "R8 no jump over run", jumps, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule